// File: doc/BRIEF.md
# Trigger Gate and Busy Sequencer

This block paces first-level triggers in a detector readout. Four candidate trigger lines are masked and merged into one request. A rising edge of that request, seen while the gate is open, is latched and closes the gate. The block then waits for the second-level decision. Either a second-level trigger edge or an abort edge moves it to a wait state. It stays there until the merged detector busy goes low. The falling edge of that busy makes a one-cycle Reset. Reset drops the latched trigger and opens the gate again.

Every input passes through a two-flop synchronizer before any edge is detected. The abort lines and the eight busy lines are masked per line and merged into one abort level and one busy level. The busy lines sit in two banks of four. Trigger edges that arrive while the gate is closed are counted in a saturating counter. A small register port holds the enable masks and carries two commands: a one-cycle manual abort, and a manual reset that clears the counter and then pulses the merged busy. The same port reads back the sequencer state, the raw busy lines and the counter.

Top module: `trig_gate_seq`

## Requirements
- R1: Reset state: flt_latched, abort_out, busy_out and reset_pulse are 0. Every register address 0 to 6 reads 0, and the status at address 4 reads 0 (gate open).
- R2: An input edge sets flt_latched in the third cycle. The edge is a rising edge of the OR of flt_in lines whose enable bit is 1 in address 0 (bit i enables line i). flt_latched is still 0 after two clock edges and is 1 after three. A line whose enable bit is 0 has no effect.
- R3: While the trigger is held (status 1), a rising edge of slt_in moves the state to status 2 (waiting for busy). flt_latched stays high until the next Reset.
- R4: abort_out is the OR of the abort_in lines enabled in address 1 (bit i enables line i). It follows the inputs two clock edges later. A disabled line leaves abort_out low and the state unchanged. An abort rising edge while status is 1 moves the state to status 2.
- R5: Writing address 3 with bit 0 set drives abort_out high for exactly one cycle after the write edge. While status is 1, this moves the state to status 2.
- R6: busy_out is the OR of the enabled busy_in lines, two edges after the inputs. Line i is enabled by bit i of address 2. Index bit 2 selects the bank and bits 1:0 select the line within the bank.
- R7: A falling edge of busy_out makes reset_pulse high for exactly one cycle. On the next edge the state returns to status 0 and flt_latched clears.
- R8: A trigger edge that arrives while the gate is closed does not change the state. It adds one to the rejected-trigger count at address 6, which stops at its all-ones value.
- R9: Writing address 3 with bit 1 set clears the rejected count on the write edge. busy_out is high for the next cycle only, and then a normal Reset follows.
- R10: Address 5 reads the synchronized raw busy_in lines (bit i for line i), whatever their enables.
- R11: If a Reset and a trigger edge fall in the same cycle, Reset wins: the gate opens, the trigger is not latched and it counts as rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_in | input | NFLT | First-level trigger candidate lines |
| abort_in | input | NABT | Abort request lines |
| slt_in | input | 1 | Second-level trigger |
| busy_in | input | NBANK*BANK_W | Detector busy lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational on address) |
| flt_latched | output | 1 | Latched trigger level (gate closed when high) |
| abort_out | output | 1 | Merged abort level |
| busy_out | output | 1 | Merged busy level |
| reset_pulse | output | 1 | One-cycle Reset at the end of busy |

## Verification
A Reset and a fresh trigger edge can fall in the same cycle. The bench provokes this by lowering the only enabled busy line in the same cycle that it raises an enabled trigger line. Both signals then cross their synchronizers together and meet at one edge. The outcome is judged from the ports: reset_pulse goes high, the state returns to open with no trigger latched, and the rejected count goes up by one. A later trigger edge is then latched as usual.

// File: rtl/tgs_pkg.sv
package tgs_pkg;

    typedef enum logic [1:0] {
        ST_OPEN = 2'd0,
        ST_HELD = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;

    localparam logic [2:0] ADR_FLT_EN  = 3'd0;
    localparam logic [2:0] ADR_ABT_EN  = 3'd1;
    localparam logic [2:0] ADR_BSY_EN  = 3'd2;
    localparam logic [2:0] ADR_CMD     = 3'd3;
    localparam logic [2:0] ADR_STATUS  = 3'd4;
    localparam logic [2:0] ADR_BSY_PAT = 3'd5;
    localparam logic [2:0] ADR_REJECT  = 3'd6;

    localparam int CMD_ABORT_BIT = 0;
    localparam int CMD_RESET_BIT = 1;

    typedef struct packed {
        logic flt;
        logic slt;
        logic abt;
        logic rst;
    } seq_evt_t;

endpackage

// File: rtl/tgs_sync.sv
module tgs_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/tgs_regs.sv
module tgs_regs
    import tgs_pkg::*;
#(
    parameter int NFLT   = 4,
    parameter int NABT   = 4,
    parameter int NBUSY  = 8,
    parameter int REJ_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  seq_state_t        state,
    input  logic [NBUSY-1:0]  busy_raw,
    input  logic [REJ_W-1:0]  rej_cnt,
    output logic [NFLT-1:0]   flt_en,
    output logic [NABT-1:0]   abt_en,
    output logic [NBUSY-1:0]  bsy_en,
    output logic              man_abort,
    output logic              man_reset,
    output logic              clr_rej,
    output logic [DATA_W-1:0] rdata
);
    logic cmd_wr;
    logic unused_wdata;

    assign cmd_wr       = wr && (addr == ADR_CMD);
    assign clr_rej      = cmd_wr && wdata[CMD_RESET_BIT];
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_en    <= '0;
            abt_en    <= '0;
            bsy_en    <= '0;
            man_abort <= 1'b0;
            man_reset <= 1'b0;
        end else begin
            man_abort <= cmd_wr && wdata[CMD_ABORT_BIT];
            man_reset <= cmd_wr && wdata[CMD_RESET_BIT];
            if (wr) begin
                case (addr)
                    ADR_FLT_EN: flt_en <= wdata[NFLT-1:0];
                    ADR_ABT_EN: abt_en <= wdata[NABT-1:0];
                    ADR_BSY_EN: bsy_en <= wdata[NBUSY-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_FLT_EN:  rdata[NFLT-1:0]  = flt_en;
            ADR_ABT_EN:  rdata[NABT-1:0]  = abt_en;
            ADR_BSY_EN:  rdata[NBUSY-1:0] = bsy_en;
            ADR_STATUS:  rdata[1:0]       = state;
            ADR_BSY_PAT: rdata[NBUSY-1:0] = busy_raw;
            ADR_REJECT:  rdata[REJ_W-1:0] = rej_cnt;
            default:     rdata            = '0;
        endcase
    end
endmodule

// File: rtl/tgs_seq.sv
module tgs_seq
    import tgs_pkg::*;
#(
    parameter int REJ_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flt_lvl,
    input  logic             slt_lvl,
    input  logic             abt_lvl,
    input  logic             busy_lvl,
    input  logic             clr_rej,
    output seq_state_t       state,
    output logic             rst_pulse,
    output logic [REJ_W-1:0] rej_cnt
);
    localparam logic [REJ_W-1:0] REJ_MAX = {REJ_W{1'b1}};

    logic       flt_prev, slt_prev, abt_prev, busy_prev;
    seq_evt_t   evt;
    seq_state_t nxt;
    logic       accept, reject;

    always_comb begin
        evt.flt   = flt_lvl  & ~flt_prev;
        evt.slt   = slt_lvl  & ~slt_prev;
        evt.abt   = abt_lvl  & ~abt_prev;
        evt.rst   = busy_prev & ~busy_lvl;
        rst_pulse = evt.rst;
        accept    = evt.flt && (state == ST_OPEN) && !evt.rst;
        reject    = evt.flt && !accept;
        nxt       = state;
        if (evt.rst) begin
            nxt = ST_OPEN;
        end else begin
            case (state)
                ST_OPEN: if (accept) nxt = ST_HELD;
                ST_HELD: if (evt.slt || evt.abt) nxt = ST_WAIT;
                default: nxt = ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_OPEN;
            flt_prev  <= 1'b0;
            slt_prev  <= 1'b0;
            abt_prev  <= 1'b0;
            busy_prev <= 1'b0;
            rej_cnt   <= '0;
        end else begin
            state     <= nxt;
            flt_prev  <= flt_lvl;
            slt_prev  <= slt_lvl;
            abt_prev  <= abt_lvl;
            busy_prev <= busy_lvl;
            if (clr_rej)
                rej_cnt <= '0;
            else if (reject && rej_cnt != REJ_MAX)
                rej_cnt <= rej_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/trig_gate_seq.sv
module trig_gate_seq
    import tgs_pkg::*;
#(
    parameter int NFLT   = 4,
    parameter int NABT   = 4,
    parameter int NBANK  = 2,
    parameter int BANK_W = 4,
    parameter int REJ_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NFLT-1:0]         flt_in,
    input  logic [NABT-1:0]         abort_in,
    input  logic                    slt_in,
    input  logic [NBANK*BANK_W-1:0] busy_in,
    input  logic                    reg_wr,
    input  logic [2:0]              reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    output logic                    flt_latched,
    output logic                    abort_out,
    output logic                    busy_out,
    output logic                    reset_pulse
);
    localparam int NBUSY  = NBANK * BANK_W;
    localparam int SYNC_W = NFLT + NABT + 1 + NBUSY;

    logic [SYNC_W-1:0] sync_q;
    logic [NFLT-1:0]   flt_s, flt_en;
    logic [NABT-1:0]   abt_s, abt_en;
    logic              slt_s;
    logic [NBUSY-1:0]  busy_s, bsy_en;
    logic [NBANK-1:0]  bank_busy;
    logic              man_abort, man_reset, clr_rej;
    logic              flt_lvl;
    logic [REJ_W-1:0]  rej_cnt;
    seq_state_t        state;

    tgs_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({flt_in, abort_in, slt_in, busy_in}),
        .q   (sync_q)
    );

    assign {flt_s, abt_s, slt_s, busy_s} = sync_q;

    genvar g;
    generate
        for (g = 0; g < NBANK; g++) begin : g_bank
            assign bank_busy[g] = |(busy_s[g*BANK_W +: BANK_W] & bsy_en[g*BANK_W +: BANK_W]);
        end
    endgenerate

    assign flt_lvl   = |(flt_s & flt_en);
    assign abort_out = (|(abt_s & abt_en)) | man_abort;
    assign busy_out  = (|bank_busy) | man_reset;

    tgs_regs #(
        .NFLT(NFLT), .NABT(NABT), .NBUSY(NBUSY), .REJ_W(REJ_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .state     (state),
        .busy_raw  (busy_s),
        .rej_cnt   (rej_cnt),
        .flt_en    (flt_en),
        .abt_en    (abt_en),
        .bsy_en    (bsy_en),
        .man_abort (man_abort),
        .man_reset (man_reset),
        .clr_rej   (clr_rej),
        .rdata     (reg_rdata)
    );

    tgs_seq #(.REJ_W(REJ_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .flt_lvl   (flt_lvl),
        .slt_lvl   (slt_s),
        .abt_lvl   (abort_out),
        .busy_lvl  (busy_out),
        .clr_rej   (clr_rej),
        .state     (state),
        .rst_pulse (reset_pulse),
        .rej_cnt   (rej_cnt)
    );

    assign flt_latched = (state != ST_OPEN);
endmodule

// File: rtl/trig_gate_seq_chk.sv
module trig_gate_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       cmd_abort,
    input logic       cmd_reset,
    input logic       flt_latched,
    input logic       abort_out,
    input logic       busy_out,
    input logic       reset_pulse
);
    logic cmd_wr;
    assign cmd_wr = reg_wr && (reg_addr == 3'd3);

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
        reset_pulse |=> !reset_pulse);

    assert_pulse_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
        reset_pulse |-> (!busy_out && $past(busy_out)));

    assert_reset_opens_R7: assert property (@(posedge clk) disable iff (rst)
        reset_pulse |=> !flt_latched);

    assert_hold_until_reset_R3: assert property (@(posedge clk) disable iff (rst)
        (flt_latched && !reset_pulse) |=> flt_latched);

    assert_man_abort_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_abort) |=> abort_out);

    assert_man_reset_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_reset) |=> busy_out);
endmodule

bind trig_gate_seq trig_gate_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .cmd_abort   (reg_wdata[0]),
    .cmd_reset   (reg_wdata[1]),
    .flt_latched (flt_latched),
    .abort_out   (abort_out),
    .busy_out    (busy_out),
    .reset_pulse (reset_pulse)
);

// File: tb/tb_trig_gate_seq.sv
module tb_trig_gate_seq;
    localparam int REJ_W = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  flt_in = '0;
    logic [3:0]  abort_in = '0;
    logic        slt_in = 1'b0;
    logic [7:0]  busy_in = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        flt_latched, abort_out, busy_out, reset_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trig_gate_seq #(.REJ_W(REJ_W)) dut (
        .clk(clk), .rst(rst), .flt_in(flt_in), .abort_in(abort_in),
        .slt_in(slt_in), .busy_in(busy_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flt_latched(flt_latched), .abort_out(abort_out),
        .busy_out(busy_out), .reset_pulse(reset_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic mreset();
        wr(3'd3, 16'h0002);
        cyc(2);
    endtask

    task automatic latch_flt();
        wr(3'd0, 16'h0001);
        flt_in[0] = 1'b1; cyc(3);
        flt_in[0] = 1'b0; cyc(2);
    endtask

    initial begin
        int v;
        cyc(5);
        rst = 1'b0;
        // R1 reset state
        check("R1 flt_latched", flt_latched, 0);
        check("R1 abort_out", abort_out, 0);
        check("R1 busy_out", busy_out, 0);
        check("R1 reset_pulse", reset_pulse, 0);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            check("R1 register", v, 0);
        end
        cyc(1);

        // R2 sweep of FLT enable masks and lines
        for (int m = 0; m < 16; m++) begin
            for (int l = 0; l < 4; l++) begin
                wr(3'd0, 16'(m));
                flt_in[l] = 1'b1;
                cyc(2);
                check("R2 not before third edge", flt_latched, 0);
                cyc(1);
                check("R2 latch by enable", flt_latched, (m >> l) & 1);
                flt_in[l] = 1'b0;
                cyc(2);
                mreset();
                check("R7 open after manual reset", flt_latched, 0);
            end
        end

        // R3 SLT moves to wait, latch kept
        latch_flt();
        rd(3'd4, v); check("R3 held status", v, 1);
        slt_in = 1'b1; cyc(3); slt_in = 1'b0;
        rd(3'd4, v); check("R3 wait status", v, 2);
        check("R3 latch kept", flt_latched, 1);

        // R8 rejects counted and saturate at 7
        for (int k = 0; k < 3; k++) begin
            flt_in[0] = 1'b1; cyc(2); flt_in[0] = 1'b0; cyc(2);
        end
        cyc(1);
        rd(3'd6, v); check("R8 reject count", v, 3);
        rd(3'd4, v); check("R8 state unchanged", v, 2);
        for (int k = 0; k < 6; k++) begin
            flt_in[0] = 1'b1; cyc(2); flt_in[0] = 1'b0; cyc(2);
        end
        cyc(1);
        rd(3'd6, v); check("R8 reject saturates", v, 7);

        // R9 manual reset sequence
        wr(3'd3, 16'h0002);
        rd(3'd6, v); check("R9 count cleared", v, 0);
        check("R9 busy toggled", busy_out, 1);
        cyc(1);
        check("R9 reset pulse", reset_pulse, 1);
        check("R9 busy back low", busy_out, 0);
        cyc(1);
        check("R9 pulse one cycle", reset_pulse, 0);
        rd(3'd4, v); check("R9 state open", v, 0);

        // R4 abort lines
        wr(3'd1, 16'h0005);
        latch_flt();
        abort_in[1] = 1'b1; cyc(3);
        check("R4 disabled abort", abort_out, 0);
        rd(3'd4, v); check("R4 disabled no move", v, 1);
        abort_in[1] = 1'b0; abort_in[2] = 1'b1; cyc(2);
        check("R4 enabled abort", abort_out, 1);
        cyc(1);
        rd(3'd4, v); check("R4 abort to wait", v, 2);
        abort_in[2] = 1'b0; cyc(2);
        check("R4 abort low", abort_out, 0);
        mreset();

        // R5 manual abort
        latch_flt();
        wr(3'd3, 16'h0001);
        check("R5 abort high", abort_out, 1);
        cyc(1);
        check("R5 abort one cycle", abort_out, 0);
        rd(3'd4, v); check("R5 abort to wait", v, 2);
        mreset();

        // R6 R7 R10 busy sweep over all masks and lines
        for (int m = 0; m < 256; m++) begin
            for (int l = 0; l < 8; l++) begin
                wr(3'd2, 16'(m));
                busy_in[l] = 1'b1; cyc(2);
                check("R6 busy merge", busy_out, (m >> l) & 1);
                rd(3'd5, v); check("R10 busy pattern", v, 1 << l);
                busy_in[l] = 1'b0; cyc(2);
                check("R7 pulse on fall", reset_pulse, (m >> l) & 1);
                cyc(1);
                check("R7 pulse ends", reset_pulse, 0);
            end
        end

        // R11 reset and trigger edge in same cycle
        wr(3'd2, 16'h0000);
        mreset();
        wr(3'd2, 16'h0001);
        busy_in[0] = 1'b1;
        latch_flt();
        slt_in = 1'b1; cyc(3); slt_in = 1'b0;
        rd(3'd4, v); check("R11 in wait", v, 2);
        busy_in[0] = 1'b0; flt_in[0] = 1'b1;
        cyc(2);
        check("R11 reset pulse", reset_pulse, 1);
        cyc(1);
        check("R11 not latched", flt_latched, 0);
        rd(3'd6, v); check("R11 counted rejected", v, 1);
        flt_in[0] = 1'b0; cyc(2);
        flt_in[0] = 1'b1; cyc(3);
        check("R11 later trigger latched", flt_latched, 1);
        flt_in[0] = 1'b0;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule